// File: doc/BRIEF.md
# SPI status-bit auto-poll engine

This engine takes the job of waiting on a serial flash away from software. Once started, it repeatedly runs a short SPI exchange with the device. Each exchange selects the device, sends a configured one-byte command, clocks in one response byte and then deselects the device. The engine tests one chosen bit of the response against an expected polarity. It stops when the bit matches (success) or when a try budget runs out (timeout). The budget scales with the serial clock rate, so that a given timeout setting covers roughly the same wall time at any speed.

The engine does not contain the byte shifter or the clock divider. It hands each byte to a shared shifter over a valid/ready request channel. It receives each returned byte on a response strobe, which carries no back-pressure: the engine keeps at most one byte in flight and accepts the response in any cycle. The engine also owns a three-source interrupt status register, with a mask and one interrupt line. A transfer-finished strobe from the block-transfer master feeds one of the three sources.

Configuration uses a small write port. Select value 0 writes the poll register, 1 writes the mask and 2 writes the status register as write-one-to-clear. The poll register, mask and status can always be read on plain output pins.

Top module: `autopoll_engine`

## Requirements
- R1: After reset the poll readback, mask, status, interrupt, chip select and request valid are all 0.
- R2: A poll-register write with bit 31 set, made while idle, starts polling. The command is taken from bits 7:0, the timeout from bits 19:16, the tested bit index from bits 26:24 and the expected polarity from bit 30. These fields read back in the same positions. Bit 31 reads 1 for as long as polling is active.
- R3: Each try asserts chip select and issues two byte requests: the command byte first, then 0x00. Only the response to the second request is tested. Chip select drops after that response.
- R4: If the tested response bit equals the expected polarity, polling stops: bit 31 clears and status bit 1 (success) is set.
- R5: The try budget is (31 << baud code) + timeout field, latched at start. If that many tries complete without a match, polling stops with status bit 2 (timeout) set.
- R6: Every completed try that is not aborted sets status bit 0 (transfer finished). A pulse on the transfer-finished input also sets status bit 0.
- R7: Between tries, chip select stays low for exactly 8 serial clock periods. One serial clock period is 2 << baud code clock cycles, so the gap is 16 << baud code cycles.
- R8: Writing the poll register with bit 31 clear during polling aborts it. A try in progress runs to completion, and that try sets no status bit. An abort that arrives during the gap stops polling at once. Bit 31 stays 1 until the engine is idle.
- R9: While polling is active, poll-register writes have no effect on the stored fields. A write with bit 31 set does not restart polling.
- R10: Writing 1 to a status bit clears it. If hardware sets the same bit in the same cycle, the bit ends up set.
- R11: A mask bit of 1 disables its source. The interrupt output pulses high for one cycle, in the cycle after an unmasked status bit goes from 0 to 1. Unmasking a bit that is already set raises no pulse.
- R12: Once request valid is high, it stays high with stable data until ready is seen, and it is high only while chip select is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_i | input | 3 | Serial clock rate code shared with the transfer master |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 poll, 1 mask, 2 status |
| cfg_wdata_i | input | 32 | Register write data |
| poll_q_o | output | 32 | Poll register readback, bit 31 = active |
| mask_o | output | 3 | Interrupt mask readback |
| status_o | output | 3 | Interrupt status: 0 transfer, 1 success, 2 timeout |
| xfer_done_i | input | 1 | Transfer-finished pulse from the block-transfer master |
| req_valid_o | output | 1 | Byte request to shifter valid |
| req_ready_i | input | 1 | Shifter accepts the byte request |
| req_data_o | output | 8 | Byte to shift out |
| rsp_valid_i | input | 1 | Shifted-in byte strobe |
| rsp_data_i | input | 8 | Shifted-in byte |
| cs_o | output | 1 | Device select, active high |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The case that needs care is a software clear of a status bit landing in the same cycle as a hardware set of that same bit. The bench produces it by driving a write-one-to-clear of status bit 0 and a transfer-finished pulse on the same falling edge. It then expects the bit to stay set and one interrupt pulse to appear in the next cycle. A second overlap comes from the abort: the abort write reaches the engine while a try is still in flight. Here the bench clears status beforehand and expects the status register to be all zero once the engine goes idle.

// File: rtl/ap_pkg.sv
package ap_pkg;
  localparam int REG_W    = 32;
  localparam int CMD_LSB  = 0;
  localparam int TMO_LSB  = 16;
  localparam int BSEL_LSB = 24;
  localparam int POL_BIT  = 30;
  localparam int GO_BIT   = 31;

  localparam int NSRC    = 3;
  localparam int SRC_XFR = 0;
  localparam int SRC_HIT = 1;
  localparam int SRC_TMO = 2;

  typedef enum logic [1:0] {
    SEL_POLL = 2'd0,
    SEL_MASK = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD_REQ,
    S_CMD_WAIT,
    S_RSP_REQ,
    S_RSP_WAIT,
    S_GAP
  } seq_state_e;
endpackage

// File: rtl/ap_try_budget.sv
module ap_try_budget #(
  parameter int BAUD_W = 3,
  parameter int TMO_W  = 4,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic [TMO_W-1:0]  tmo_i,
  input  logic              tick_i,
  output logic              last_o
);
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left_q <= '0;
    else if (load_i) left_q <= (CNT_W'(31) << baud_i) + CNT_W'(tmo_i);
    else if (tick_i && left_q != '0) left_q <= left_q - 1'b1;
  end

  assign last_o = (left_q == CNT_W'(1));

  // a try never completes once the budget is spent
  assert_budget_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |-> left_q != '0);
endmodule

// File: rtl/ap_irq_ctrl.sv
module ap_irq_ctrl #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_d_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] status_q, mask_q;
  logic         irq_q;
  logic [N-1:0] rise;

  assign rise = set_i & ~status_q & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_i) | set_i;
      if (mask_we_i) mask_q <= mask_d_i;
      irq_q <= |rise;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  for (genvar b = 0; b < N; b++) begin : g_chk
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[b] |=> status_q[b]);
    assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[b] && !set_i[b]) |=> !status_q[b]);
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[b] && !clr_i[b]) |=> status_q[b]);
  end

  assert_irq_has_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (|status_q));
endmodule

// File: rtl/ap_poll_seq.sv
module ap_poll_seq
  import ap_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int BSEL_W   = 3,
  parameter int BAUD_W   = 3,
  parameter int GAP_SCLK = 8,
  parameter int GAP_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [BSEL_W-1:0] bsel_i,
  input  logic              pol_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              last_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [BYTE_W-1:0] req_data_o,
  input  logic              rsp_valid_i,
  input  logic [BYTE_W-1:0] rsp_data_i,
  output logic              cs_o,
  output logic              busy_o,
  output logic              tick_o,
  output logic              hit_o,
  output logic              tmo_o
);
  seq_state_e       state_q, state_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [GAP_W-1:0] gap_len;

  assign gap_len = GAP_W'(2 * GAP_SCLK) << baud_i;

  always_comb begin
    state_d = state_q;
    gap_d   = gap_q;
    tick_o  = 1'b0;
    hit_o   = 1'b0;
    tmo_o   = 1'b0;
    case (state_q)
      S_IDLE:     if (start_i) state_d = S_CMD_REQ;
      S_CMD_REQ:  if (req_ready_i) state_d = S_CMD_WAIT;
      S_CMD_WAIT: if (rsp_valid_i) state_d = S_RSP_REQ;
      S_RSP_REQ:  if (req_ready_i) state_d = S_RSP_WAIT;
      S_RSP_WAIT: begin
        if (rsp_valid_i) begin
          if (abort_i) begin
            state_d = S_IDLE;
          end else begin
            tick_o = 1'b1;
            if (rsp_data_i[bsel_i] == pol_i) begin
              hit_o   = 1'b1;
              state_d = S_IDLE;
            end else if (last_i) begin
              tmo_o   = 1'b1;
              state_d = S_IDLE;
            end else begin
              state_d = S_GAP;
              gap_d   = gap_len - 1'b1;
            end
          end
        end
      end
      S_GAP: begin
        if (abort_i)            state_d = S_IDLE;
        else if (gap_q == '0)   state_d = S_CMD_REQ;
        else                    gap_d   = gap_q - 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
    end
  end

  assign req_valid_o = (state_q == S_CMD_REQ) || (state_q == S_RSP_REQ);
  assign req_data_o  = (state_q == S_CMD_REQ) ? cmd_i : '0;
  assign cs_o        = (state_q != S_IDLE) && (state_q != S_GAP);
  assign busy_o      = (state_q != S_IDLE);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_data_o)));
  assert_req_in_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> cs_o);
  assert_cs_drop_after_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_o) |-> $past(rsp_valid_i));
  assert_stop_on_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_o || tmo_o) |=> !busy_o);
endmodule

// File: rtl/autopoll_engine.sv
module autopoll_engine
  import ap_pkg::*;
#(
  parameter int BAUD_W   = 3,
  parameter int TMO_W    = 4,
  parameter int BYTE_W   = 8,
  parameter int GAP_SCLK = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  output logic [REG_W-1:0]  poll_q_o,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   status_o,
  input  logic              xfer_done_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [BYTE_W-1:0] req_data_o,
  input  logic              rsp_valid_i,
  input  logic [BYTE_W-1:0] rsp_data_i,
  output logic              cs_o,
  output logic              irq_o
);
  localparam int BSEL_W    = $clog2(BYTE_W);
  localparam int MAX_BAUD  = (1 << BAUD_W) - 1;
  localparam int MAX_TRIES = (31 << MAX_BAUD) + (1 << TMO_W) - 1;
  localparam int CNT_W     = $clog2(MAX_TRIES + 1);
  localparam int MAX_GAP   = (2 * GAP_SCLK) << MAX_BAUD;
  localparam int GAP_W     = $clog2(MAX_GAP + 1);

  logic [BYTE_W-1:0] cmd_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [BSEL_W-1:0] bsel_q;
  logic              pol_q;
  logic [BAUD_W-1:0] baud_q;
  logic              abort_q;

  logic busy, tick, hit, tmo, last;
  logic wr_poll, start, abort_wr;
  logic wdata_unused;

  assign wdata_unused = ^cfg_wdata_i;

  assign wr_poll  = cfg_we_i && (cfg_sel_i == SEL_POLL);
  assign start    = wr_poll && cfg_wdata_i[GO_BIT] && !busy;
  assign abort_wr = wr_poll && !cfg_wdata_i[GO_BIT] && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      tmo_q   <= '0;
      bsel_q  <= '0;
      pol_q   <= 1'b0;
      baud_q  <= '0;
      abort_q <= 1'b0;
    end else begin
      if (start) begin
        cmd_q  <= cfg_wdata_i[CMD_LSB +: BYTE_W];
        tmo_q  <= cfg_wdata_i[TMO_LSB +: TMO_W];
        bsel_q <= cfg_wdata_i[BSEL_LSB +: BSEL_W];
        pol_q  <= cfg_wdata_i[POL_BIT];
        baud_q <= baud_i;
      end
      if (start || !busy) abort_q <= 1'b0;
      else if (abort_wr)  abort_q <= 1'b1;
    end
  end

  always_comb begin
    poll_q_o = '0;
    poll_q_o[CMD_LSB +: BYTE_W]  = cmd_q;
    poll_q_o[TMO_LSB +: TMO_W]   = tmo_q;
    poll_q_o[BSEL_LSB +: BSEL_W] = bsel_q;
    poll_q_o[POL_BIT]            = pol_q;
    poll_q_o[GO_BIT]             = busy;
  end

  ap_try_budget #(
    .BAUD_W(BAUD_W), .TMO_W(TMO_W), .CNT_W(CNT_W)
  ) u_budget (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start),
    .baud_i (baud_i),
    .tmo_i  (cfg_wdata_i[TMO_LSB +: TMO_W]),
    .tick_i (tick),
    .last_o (last)
  );

  ap_poll_seq #(
    .BYTE_W(BYTE_W), .BSEL_W(BSEL_W), .BAUD_W(BAUD_W),
    .GAP_SCLK(GAP_SCLK), .GAP_W(GAP_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .abort_i     (abort_q),
    .cmd_i       (cmd_q),
    .bsel_i      (bsel_q),
    .pol_i       (pol_q),
    .baud_i      (baud_q),
    .last_i      (last),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_data_o  (req_data_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_data_i  (rsp_data_i),
    .cs_o        (cs_o),
    .busy_o      (busy),
    .tick_o      (tick),
    .hit_o       (hit),
    .tmo_o       (tmo)
  );

  logic [NSRC-1:0] set_vec, clr_vec;

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_XFR] = tick | xfer_done_i;
    set_vec[SRC_HIT] = hit;
    set_vec[SRC_TMO] = tmo;
    clr_vec = (cfg_we_i && cfg_sel_i == SEL_STAT) ? cfg_wdata_i[NSRC-1:0] : '0;
  end

  ap_irq_ctrl #(.N(NSRC)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (set_vec),
    .clr_i     (clr_vec),
    .mask_we_i (cfg_we_i && cfg_sel_i == SEL_MASK),
    .mask_d_i  (cfg_wdata_i[NSRC-1:0]),
    .status_o  (status_o),
    .mask_o    (mask_o),
    .irq_o     (irq_o)
  );

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({cmd_q, tmo_q, bsel_q, pol_q, baud_q}));
  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> !(hit || tmo));
endmodule

// File: tb/tb_autopoll_engine.sv
module tb_autopoll_engine;
  import ap_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  baud;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic [31:0] poll_q;
  logic [2:0]  mask, status;
  logic        xfer_done;
  logic        req_valid, req_ready;
  logic [7:0]  req_data, rsp_data;
  logic        rsp_valid, cs, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  autopoll_engine dut (
    .clk(clk), .rst_n(rst_n), .baud_i(baud),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .poll_q_o(poll_q), .mask_o(mask), .status_o(status),
    .xfer_done_i(xfer_done),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_data_o(req_data),
    .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data),
    .cs_o(cs), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // device / shifter model state
  int total_tries = 0, proto_err = 0, xpar = 0;
  int cur_base = 0, flip_at = 0;
  logic [7:0] exp_cmd = 8'h00, match_byte = 8'h00, miss_byte = 8'h00;

  initial begin : shifter_model
    logic [7:0] first_data;
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = 8'h00;
    forever begin
      @(negedge clk);
      if (req_valid) begin
        first_data = req_data;
        repeat (2) @(negedge clk);
        // R12: held with stable data; R3: inside chip select, byte order
        if (!req_valid || req_data != first_data || !cs) proto_err++;
        if (xpar == 0 && req_data != exp_cmd) proto_err++;
        if (xpar == 1 && req_data != 8'h00) proto_err++;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        repeat (2) @(negedge clk);
        if (xpar == 0) rsp_data = 8'h5A;
        else begin
          rsp_data = ((total_tries - cur_base) >= flip_at) ? match_byte : miss_byte;
          total_tries++;
        end
        xpar ^= 1;
        rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  typedef struct {
    int         tries;
    logic [2:0] st;
    int         irqs;
    int         try_base;
    int         irq_base;
    int         gap_base;
  } exp_t;
  exp_t sb_q[$];

  int irq_total = 0, gap_run = 0, gap_seen = 0, gap_err = 0, exp_gap = 16;
  int polls_done = 0;
  bit prev_busy = 1'b0;

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) irq_total++;
      if (poll_q[31] && !cs) gap_run++;
      else begin
        if (poll_q[31] && cs && gap_run > 0) begin
          gap_seen++;
          if (gap_run != exp_gap) gap_err++;
        end
        gap_run = 0;
      end
      if (prev_busy && !poll_q[31]) begin
        if (sb_q.size() == 0) chk(1'b0, "scoreboard empty", 0, 1);
        else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(total_tries - e.try_base == e.tries, "R4/R5 try count",
              total_tries - e.try_base, e.tries);
          chk(status == e.st, "R4/R5/R6/R8 status", status, e.st);
          chk(irq_total - e.irq_base == e.irqs, "R11 irq pulses",
              irq_total - e.irq_base, e.irqs);
          chk(proto_err == 0, "R3/R12 exchange protocol", proto_err, 0);
          chk(gap_err == 0 && gap_seen - e.gap_base == e.tries - 1,
              "R7 inter-try gap", gap_seen - e.gap_base, e.tries - 1);
        end
        polls_done++;
      end
      prev_busy = poll_q[31];
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic start_poll(input logic [7:0] c, input logic [3:0] t, input logic [2:0] bs,
                            input logic p, input logic [2:0] bd, input logic [2:0] m,
                            input int flip, input logic [7:0] hit_b, input logic [7:0] miss_b,
                            input int tries, input logic [2:0] st, input int irqs);
    exp_t e;
    logic [31:0] w;
    baud = bd;
    wr(SEL_MASK, {29'd0, m});
    wr(SEL_STAT, 32'h7);
    exp_cmd = c; flip_at = flip; match_byte = hit_b; miss_byte = miss_b;
    exp_gap = 16 << bd; cur_base = total_tries;
    e.tries = tries; e.st = st; e.irqs = irqs;
    e.try_base = total_tries; e.irq_base = irq_total; e.gap_base = gap_seen;
    sb_q.push_back(e);
    w = {1'b1, p, 3'b000, bs, 4'h0, t, 8'h00, c};
    wr(SEL_POLL, w);
    chk(poll_q == w, "R2 start and field readback", poll_q, w);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : driver
    int base;
    baud = 3'd0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 32'h0; xfer_done = 1'b0;
    repeat (4) @(negedge clk);
    chk(poll_q == 32'h0 && mask == 3'h0 && status == 3'h0, "R1 reset registers",
        {poll_q[31:28], mask, status}, 0);
    chk(!irq && !cs && !req_valid, "R1 reset outputs", {irq, cs, req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: clear and set of status bit 0 in the same cycle
    cfg_we = 1'b1; cfg_sel = SEL_STAT; cfg_wdata = 32'h1; xfer_done = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; xfer_done = 1'b0;
    chk(status[0] == 1'b1, "R10 set beats clear", status, 1);
    chk(irq == 1'b1, "R11 pulse after rise", irq, 1);
    @(negedge clk);
    chk(irq == 1'b0, "R11 pulse lasts one cycle", irq, 0);
    wr(SEL_STAT, 32'h1);
    chk(status == 3'h0, "R10 write-one clears", status, 0);

    // R11: masked source and later unmask
    wr(SEL_MASK, 32'h1);
    chk(mask == 3'h1, "R11 mask readback", mask, 1);
    base = irq_total;
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    chk(status[0] == 1'b1, "R6 transfer input sets bit 0", status, 1);
    repeat (2) @(negedge clk);
    chk(irq_total == base, "R11 masked source silent", irq_total - base, 0);
    wr(SEL_MASK, 32'h0);
    repeat (2) @(negedge clk);
    chk(irq_total == base, "R11 unmask of set bit silent", irq_total - base, 0);

    // success on third try, bit 0 low expected
    start_poll(8'h05, 4'h0, 3'd0, 1'b0, 3'd0, 3'h0, 2, 8'hFE, 8'h01, 3, 3'b011, 2);
    wait (polls_done == 1);

    // timeout at 31 tries; also R9 writes while busy
    start_poll(8'h9F, 4'h0, 3'd5, 1'b1, 3'd0, 3'h0, 1000, 8'h20, 8'hDF, 31, 3'b101, 2);
    wr(SEL_POLL, 32'hC70F_0033);
    chk(poll_q == 32'hC500_009F, "R9 busy write ignored", poll_q, 32'hC500_009F);
    wait (polls_done == 2);

    // baud 1, timeout field 3: 65 tries, bit 0 masked
    start_poll(8'h35, 4'h3, 3'd2, 1'b0, 3'd1, 3'h1, 1000, 8'h00, 8'h04, 65, 3'b101, 1);
    wait (polls_done == 3);

    // immediate success on bit 7 high
    start_poll(8'h70, 4'h0, 3'd7, 1'b1, 3'd0, 3'h0, 0, 8'h80, 8'h7F, 1, 3'b011, 1);
    wait (polls_done == 4);

    // R8: abort during the gap after two tries
    start_poll(8'h05, 4'h0, 3'd1, 1'b1, 3'd2, 3'h0, 1000, 8'h02, 8'h00, 2, 3'b001, 1);
    wait (total_tries == cur_base + 2);
    wr(SEL_POLL, 32'h0);
    wait (polls_done == 5);

    // R8: abort while the second try is in flight; that try sets nothing
    start_poll(8'h06, 4'hF, 3'd3, 1'b1, 3'd0, 3'h0, 1000, 8'h08, 8'h00, 2, 3'b000, 1);
    wait (total_tries == cur_base + 1);
    wait (!cs);
    wait (cs);
    wr(SEL_STAT, 32'h1);
    wr(SEL_POLL, 32'h0);
    chk(poll_q[31] == 1'b1, "R8 active until try ends", poll_q[31], 1);
    wait (polls_done == 6);

    repeat (5) @(negedge clk);
    chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule